// File: doc/BRIEF.md
# Segmented Scan Shift Controller

This controller sequences the shift phase of a set of parallel scan chains that are each cut into the same number of equal segments. Shift power is reduced because only one segment position is clocked in any shift cycle. Segment k of every chain is driven by the same clock enable, so all chains move their k-th segment together. The other segments keep their clocks held off and are skipped by bypass multiplexers, which give the active segment a path to the chain's scan-in and scan-out.

A test sequence begins when `start` is seen while `scan_en` is high. The segment nearest scan-out is shifted first and the segment nearest scan-in last. Each segment is clocked for the programmed number of cycles, so the whole shift takes the same number of cycles as shifting an unsegmented chain. When the last segment finishes, a one-cycle `done` pulse is raised. The controller then waits for `scan_en` to fall and clocks every segment in a single capture cycle, which keeps launch-off-capture delay tests working. The clock-gating cells themselves are outside the block; it produces enables only.

Top module: `seg_scan_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `seg_clk_en`, `byp_sel` and `done` are all zero.
- R2: The block samples `start` high with `scan_en` high while idle. In the next cycle shifting begins with segment NUM_SEG-1, which is nearest scan-out, and then moves down one index at a time to segment 0, which is nearest scan-in. Bit k of `seg_clk_en` is the enable of segment k.
- R3: Each segment's enable stays high for exactly L consecutive cycles, where L is the programmed length. The next segment's enable rises in the cycle right after, so the whole shift lasts NUM_SEG*L cycles.
- R4: In every shift cycle exactly one bit of `seg_clk_en` is high, and never more than one.
- R5: During shift, `byp_sel[k]` is 1 (bypass) for every segment except the active one, whose bit is 0. Outside shift, `byp_sel` is all zero.
- R6: In the cycle after the last shift cycle of segment 0, `done` is high for exactly one cycle and all enables are low.
- R7: After the done pulse, the block samples `scan_en` low. In the next cycle all bits of `seg_clk_en` are high for exactly one capture cycle, and the controller then returns to idle with all enables low.
- R8: If `scan_en` is sampled low during shift, the next cycle has all enables and bypass selects low. No `done` pulse follows, and the controller is idle.
- R9: `start` has no effect while `scan_en` is low, and none while a sequence is already in progress.
- R10: `seg_len` is captured when the sequence starts, and later changes have no effect on that sequence. A programmed length of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Scan enable; low means capture, or abort during shift |
| start | input | 1 | Begin a segmented shift sequence |
| seg_len | input | LEN_W | Shift cycles per segment (0 treated as 1) |
| seg_clk_en | output | NUM_SEG | Per-segment clock enable, bit k for segment k |
| byp_sel | output | NUM_SEG | Per-segment bypass select, 1 = segment skipped |
| done | output | 1 | One-cycle pulse after the last segment finishes |

## Verification
The checker assumes that `scan_en` stays high for the whole of a shift sequence unless an abort is intended. It also assumes that capture happens only after `scan_en` falls. Under those assumptions, it requires that an enable pattern with more than one bit set is the all-ones capture pattern, and that a capture pattern lasts one cycle. The stimulus drives `scan_en`, `start` and `seg_len` only on falling edges. It sweeps every length from 0 to 5 and aborts at several points in the shift. It raises `start` only in states where the requirements say it must be ignored, so no sequence is started twice.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_WAIT  = 2'd2,
    ST_CAPT  = 2'd3
  } sc_state_t;
endpackage

// File: rtl/seg_seq.sv
module seg_seq
  import seg_scan_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int LEN_W   = 8,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_en,
  input  logic             start,
  input  logic [LEN_W-1:0] seg_len,
  output sc_state_t        nxt_state,
  output logic [SEG_W-1:0] nxt_seg,
  output logic             nxt_done
);
  sc_state_t        state_q;
  logic [SEG_W-1:0] seg_q;
  logic [LEN_W-1:0] cnt_q, nxt_cnt;
  logic [LEN_W-1:0] len_q, nxt_len;
  logic [LEN_W-1:0] len_eff;

  assign len_eff = (seg_len == '0) ? LEN_W'(1) : seg_len;

  always_comb begin
    nxt_state = state_q;
    nxt_seg   = seg_q;
    nxt_cnt   = cnt_q;
    nxt_len   = len_q;
    nxt_done  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (scan_en && start) begin
          nxt_state = ST_SHIFT;
          nxt_seg   = SEG_W'(NUM_SEG - 1);
          nxt_cnt   = len_eff - LEN_W'(1);
          nxt_len   = len_eff;
        end
      end
      ST_SHIFT: begin
        if (!scan_en) begin
          nxt_state = ST_IDLE;
          nxt_seg   = '0;
        end else if (cnt_q == '0) begin
          if (seg_q == '0) begin
            nxt_state = ST_WAIT;
            nxt_done  = 1'b1;
          end else begin
            nxt_seg = seg_q - SEG_W'(1);
            nxt_cnt = len_q - LEN_W'(1);
          end
        end else begin
          nxt_cnt = cnt_q - LEN_W'(1);
        end
      end
      ST_WAIT: begin
        if (!scan_en) nxt_state = ST_CAPT;
      end
      ST_CAPT: begin
        nxt_state = ST_IDLE;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      seg_q   <= '0;
      cnt_q   <= '0;
      len_q   <= LEN_W'(1);
    end else begin
      state_q <= nxt_state;
      seg_q   <= nxt_seg;
      cnt_q   <= nxt_cnt;
      len_q   <= nxt_len;
    end
  end
endmodule

// File: rtl/seg_decode.sv
module seg_decode
  import seg_scan_pkg::*;
#(
  parameter int NUM_SEG = 4,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  sc_state_t          nxt_state,
  input  logic [SEG_W-1:0]   nxt_seg,
  input  logic               nxt_done,
  output logic [NUM_SEG-1:0] seg_clk_en,
  output logic [NUM_SEG-1:0] byp_sel,
  output logic               done
);
  logic [NUM_SEG-1:0] en_d, byp_d;
  logic               shifting, capturing;

  assign shifting  = (nxt_state == ST_SHIFT);
  assign capturing = (nxt_state == ST_CAPT);

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    logic hit;
    assign hit      = (nxt_seg == SEG_W'(k));
    assign en_d[k]  = (shifting && hit) || capturing;
    assign byp_d[k] = shifting && !hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_clk_en <= '0;
      byp_sel    <= '0;
      done       <= 1'b0;
    end else begin
      seg_clk_en <= en_d;
      byp_sel    <= byp_d;
      done       <= nxt_done;
    end
  end
endmodule

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl
  import seg_scan_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int LEN_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scan_en,
  input  logic               start,
  input  logic [LEN_W-1:0]   seg_len,
  output logic [NUM_SEG-1:0] seg_clk_en,
  output logic [NUM_SEG-1:0] byp_sel,
  output logic               done
);
  localparam int SEG_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;

  sc_state_t        nxt_state;
  logic [SEG_W-1:0] nxt_seg;
  logic             nxt_done;

  seg_seq #(.NUM_SEG(NUM_SEG), .LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .scan_en  (scan_en),
    .start    (start),
    .seg_len  (seg_len),
    .nxt_state(nxt_state),
    .nxt_seg  (nxt_seg),
    .nxt_done (nxt_done)
  );

  seg_decode #(.NUM_SEG(NUM_SEG)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .nxt_state (nxt_state),
    .nxt_seg   (nxt_seg),
    .nxt_done  (nxt_done),
    .seg_clk_en(seg_clk_en),
    .byp_sel   (byp_sel),
    .done      (done)
  );
endmodule

// File: rtl/seg_scan_ctrl_chk.sv
module seg_scan_ctrl_chk #(
  parameter int NUM_SEG = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               scan_en,
  input logic [NUM_SEG-1:0] seg_clk_en,
  input logic [NUM_SEG-1:0] byp_sel,
  input logic               done
);
  logic all_on, one_on;
  assign all_on = &seg_clk_en;
  assign one_on = (seg_clk_en != '0) && !all_on;

  AST_AT_MOST_ONE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !all_on |-> $onehot0(seg_clk_en)); // R4

  AST_BYPASS_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    one_on |-> (byp_sel == ~seg_clk_en)); // R5

  AST_BYPASS_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !one_on |-> (byp_sel == '0)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (seg_clk_en == '0)); // R6

  AST_CAPTURE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    all_on |=> (seg_clk_en == '0)); // R7

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (one_on && !scan_en) |=> (seg_clk_en == '0 && !done)); // R8

  AST_SEG_DESCENDS: assert property (@(posedge clk) disable iff (rst)
    (one_on && $past(one_on) && seg_clk_en != $past(seg_clk_en))
      |-> (seg_clk_en == ($past(seg_clk_en) >> 1))); // R2
endmodule

bind seg_scan_ctrl seg_scan_ctrl_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scan_en   (scan_en),
  .seg_clk_en(seg_clk_en),
  .byp_sel   (byp_sel),
  .done      (done)
);

// File: tb/sim_seg_scan_ctrl.sv
`timescale 1ns/1ps
module sim_seg_scan_ctrl;
  localparam int NS = 4;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scan_en = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] seg_len = '0;
  logic [NS-1:0] seg_clk_en, byp_sel;
  logic          done;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  seg_scan_ctrl #(.NUM_SEG(NS), .LEN_W(LW)) u0 (
    .clk(clk), .rst(rst), .scan_en(scan_en), .start(start), .seg_len(seg_len),
    .seg_clk_en(seg_clk_en), .byp_sel(byp_sel), .done(done)
  );

  task automatic chk(input logic [NS-1:0] en_x, input logic [NS-1:0] byp_x,
                     input logic done_x, input string req);
    n_vec++;
    if (seg_clk_en !== en_x || byp_sel !== byp_x || done !== done_x) begin
      n_bad++;
      $display("FAIL %s: en=%b byp=%b done=%b expected en=%b byp=%b done=%b",
               req, seg_clk_en, byp_sel, done, en_x, byp_x, done_x);
    end
  endtask

  // ab < 0: full sequence; otherwise scan_en drops in shift cycle ab
  task automatic run_seq(input int lenprog, input int ab, input bit relen);
    int leff;
    leff = (lenprog == 0) ? 1 : lenprog;
    @(negedge clk);
    scan_en = 1'b1; start = 1'b1; seg_len = LW'(lenprog);
    @(negedge clk);
    start = 1'b0;
    if (relen) seg_len = LW'(7);
    for (int c = 0; c < NS * leff; c++) begin
      logic [NS-1:0] e;
      e = NS'(1) << (NS - 1 - c / leff);
      chk(e, ~e, 1'b0, "R2/R3/R10 shift step");
      if (c == 1) start = 1'b1;  // R9: ignored while busy
      if (c == 2) start = 1'b0;
      if (c == ab) begin
        scan_en = 1'b0;
        @(negedge clk);
        chk('0, '0, 1'b0, "R8 abort clears");
        @(negedge clk);
        chk('0, '0, 1'b0, "R8 no done after abort");
        return;
      end
      @(negedge clk);
    end
    chk('0, '0, 1'b1, "R6 done pulse");
    start = 1'b1;  // R9: ignored while waiting
    @(negedge clk);
    chk('0, '0, 1'b0, "R6 done single");
    start = 1'b0; scan_en = 1'b0;
    @(negedge clk);
    chk('1, '0, 1'b0, "R7 capture all on");
    @(negedge clk);
    chk('0, '0, 1'b0, "R7 back to idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk('0, '0, 1'b0, "R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    chk('0, '0, 1'b0, "R1 after reset");
    // R9: start ignored while scan_en low
    start = 1'b1; seg_len = LW'(2);
    repeat (3) begin
      @(negedge clk);
      chk('0, '0, 1'b0, "R9 start without scan_en");
    end
    start = 1'b0;
    for (int l = 0; l <= 5; l++) run_seq(l, -1, 1'b0);
    run_seq(3, -1, 1'b1);          // R10 length latched
    run_seq(0, -1, 1'b1);          // R10 zero treated as one
    for (int a = 0; a < 12; a += 3) run_seq(3, a, 1'b0);  // R8
    run_seq(2, 7, 1'b0);           // R8 abort in last cycle
    run_seq(2, -1, 1'b0);          // recovery after abort
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule